// File: doc/BRIEF.md
# Residual Pair Dispatch Controller

This controller sequences the reconstruction of a macroblock's residual sub-blocks. It takes two horizontally adjacent 4x4 sub-blocks at a time and reads the two 8-bit end-of-block counts of the pair. From those counts it chooses one path for both sub-blocks: skip the pair, send only the rounded DC terms, or send every coefficient after dequantization.

For each coefficient it reads from the coefficient memory, it scales the value by the matching entry of a 16-entry factor table and passes the result to the inverse transform engine on a coefficient stream. In the cycle after each read it writes a zero back to the same address, so the consumed storage is left cleared for the next macroblock. When a pair's coefficients are out, the controller issues one command that gives the path taken, the plane, and the pixel row and column of the pair. It then waits for the engine's completion pulse before it moves to the next pair.

One start pulse processes either the luma plane (eight pairs) or both chroma planes (four pairs). A single-cycle done pulse follows the last pair.

Top module: `dqd_dispatch`

## Requirements
- R1: When both end-of-block counts of a pair are zero, the pair is skipped. There is no coefficient read, no write and no command for it.
- R2: When either count of a pair exceeds 1, both sub-blocks take the full path. All 32 coefficients of the pair are streamed in order: sub-block 0 positions 0..15, then sub-block 1 positions 0..15. Each value is the low 16 bits of the signed product coefficient × factor[position]. The command carries full=1.
- R3: When neither count exceeds 1 and at least one is nonzero, both sub-blocks take the DC path. Only position 0 of each sub-block is read. The value streamed is (low 16 bits of coefficient × factor[0] + 4) shifted right arithmetically by 3. The command carries full=0.
- R4: Every coefficient read is written back as zero one cycle later at the same address. On the DC path only positions 0 and 16 of the pair are cleared, and all other entries keep their values.
- R5: In luma mode, pairs are handled in raster order p = 0..7. Pair p uses counts 2p and 2p+1, coefficient addresses 32p..32p+31, plane code 0, pixel row 4·(p/2) and pixel column 8·(p mod 2).
- R6: In chroma mode, four pairs p = 0..3 are handled in order with the same count and address rules. The plane code is 1 for p = 0..1 and 2 for p = 2..3, the pixel row is 4·(p mod 2) and the column is 0.
- R7: After a command is issued, no further coefficient read and no further command occur until the engine's done input has been seen.
- R8: The done output pulses for exactly one cycle after the last pair has finished or been skipped. A start pulse received while a run is in progress is ignored.
- R9: After reset, all strobes (read, write, coefficient valid, command valid, done) are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (ignored while busy) |
| chroma | input | 1 | Run selection sampled at start: 0 luma, 1 both chroma planes |
| eob_flat | input | 128 | Sixteen 8-bit end-of-block counts, count k in bits [8k+7:8k] |
| dq_flat | input | 256 | Sixteen signed 16-bit factors, position k in bits [16k+15:16k] |
| coef_rd_en | output | 1 | Coefficient memory read strobe |
| coef_rd_addr | output | 8 | Coefficient read address |
| coef_rd_data | input | 16 | Read data, valid the cycle after the strobe |
| coef_wr_en | output | 1 | Coefficient memory write strobe |
| coef_wr_addr | output | 8 | Coefficient write address |
| coef_wr_data | output | 16 | Write data (always zero) |
| xf_coef_valid | output | 1 | Scaled coefficient valid to the transform engine |
| xf_coef_blk | output | 1 | Sub-block within the pair (0 left, 1 right) |
| xf_coef_idx | output | 4 | Coefficient position within the sub-block |
| xf_coef_data | output | 16 | Scaled coefficient (or rounded DC term) |
| xf_cmd_valid | output | 1 | One-cycle command to the transform engine |
| xf_cmd_full | output | 1 | 1 full transform, 0 DC-only |
| xf_cmd_plane | output | 2 | 0 luma, 1 first chroma, 2 second chroma |
| xf_cmd_row | output | 4 | Pixel row of the pair |
| xf_cmd_col | output | 4 | Pixel column of the pair |
| xf_done | input | 1 | Engine finished the last command |
| done | output | 1 | One-cycle pulse at the end of a run |

## Verification
The count patterns mix every pair class within one run: both zero, counts of 1/1, 0/1 and 1/0 (all DC), and 2/0, 0/2, 1/16 and 255/255 (all full). A wrong threshold, or a decision taken per block instead of per pair, shows up as a changed stream length and a changed command flag. The coefficients come from a pseudo-random generator, and the factors include negative and large values so that products wrap past 16 bits, which separates truncation from saturation. A dedicated DC set puts products at -5, -4, 3, 4 and 12 to pin down the rounding direction. The memory image is compared after each run, which shows that the DC path leaves positions 1..15 untouched. A chroma run with a second start pulse in flight separates the two plane codes and shows that the extra start is ignored.

// File: rtl/dqd_pkg.sv
package dqd_pkg;
  localparam int CW     = 16;               // coefficient and factor width
  localparam int EW     = 8;                // end-of-block count width
  localparam int NPOS   = 16;               // coefficients per sub-block
  localparam int NSUB   = 16;               // sub-blocks per run (maximum)
  localparam int POS_W  = $clog2(NPOS);
  localparam int SUB_W  = $clog2(NSUB);
  localparam int PAIR_W = $clog2(NSUB / 2);
  localparam int ADDR_W = $clog2(NSUB * NPOS);
  localparam int ROW_W  = 4;
  localparam int COL_W  = 4;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_EVAL  = 3'd1,
    ST_FETCH = 3'd2,
    ST_CMD   = 3'd3,
    ST_WAIT  = 3'd4
  } dqd_state_e;

  // signed product kept to the coefficient width (wraps)
  function automatic logic [CW-1:0] dq_mul(input logic signed [CW-1:0] c,
                                           input logic signed [CW-1:0] f);
    logic signed [2*CW-1:0] p;
    p = c * f;
    return p[CW-1:0];
  endfunction

  // round-half-up division by 8 on a signed value
  function automatic logic [CW-1:0] dc_round(input logic [CW-1:0] v);
    logic signed [CW:0] s;
    logic signed [CW:0] sh;
    s  = $signed({v[CW-1], v}) + $signed((CW+1)'(4));
    sh = s >>> 3;
    return sh[CW-1:0];
  endfunction

  function automatic logic needs_full(input logic [EW-1:0] e0,
                                      input logic [EW-1:0] e1);
    return (e0 > EW'(1)) || (e1 > EW'(1));
  endfunction
endpackage

// File: rtl/dqd_pair_geom.sv
module dqd_pair_geom
  import dqd_pkg::*;
#(
  parameter int LUMA_PAIRS   = 8,
  parameter int CHROMA_PAIRS = 4
) (
  input  logic [PAIR_W-1:0] pair_idx,
  input  logic              chroma,
  output logic [SUB_W-1:0]  eob_sel0,
  output logic [SUB_W-1:0]  eob_sel1,
  output logic [ADDR_W-1:0] base,
  output logic [1:0]        plane,
  output logic [ROW_W-1:0]  row,
  output logic [COL_W-1:0]  col,
  output logic              last
);
  localparam int PAIR_SPAN_SH = POS_W + 1;

  always_comb begin
    eob_sel0 = SUB_W'({pair_idx, 1'b0});
    eob_sel1 = SUB_W'({pair_idx, 1'b1});
    base     = ADDR_W'(pair_idx) << PAIR_SPAN_SH;
    if (chroma) begin
      plane = pair_idx[1] ? 2'd2 : 2'd1;
      row   = pair_idx[0] ? ROW_W'(4) : '0;
      col   = '0;
      last  = (pair_idx == PAIR_W'(CHROMA_PAIRS - 1));
    end else begin
      plane = 2'd0;
      row   = ROW_W'(pair_idx >> 1) << 2;
      col   = pair_idx[0] ? COL_W'(8) : '0;
      last  = (pair_idx == PAIR_W'(LUMA_PAIRS - 1));
    end
  end
endmodule

// File: rtl/dqd_fetch.sv
module dqd_fetch
  import dqd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic               full_in,
  input  logic [ADDR_W-1:0]  base_in,
  input  logic [NPOS*CW-1:0] dq_flat,
  output logic               rd_en,
  output logic [ADDR_W-1:0]  rd_addr,
  input  logic [CW-1:0]      rd_data,
  output logic               wr_en,
  output logic [ADDR_W-1:0]  wr_addr,
  output logic               coef_valid,
  output logic               coef_blk,
  output logic [POS_W-1:0]   coef_idx,
  output logic [CW-1:0]      coef_data,
  output logic               run_full,
  output logic               finished
);
  localparam int CNT_W = POS_W + 1;
  localparam logic [CNT_W-1:0] LAST_FULL = '1;
  localparam logic [CNT_W-1:0] LAST_DC   = CNT_W'(1);

  logic              active_q, full_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] base_q;
  logic              ret_v_q, ret_blk_q, ret_full_q, ret_last_q;
  logic [POS_W-1:0]  ret_idx_q;
  logic [ADDR_W-1:0] ret_addr_q;

  logic              cur_blk, cur_last;
  logic [POS_W-1:0]  cur_idx;
  logic [CW-1:0]     factor, product;

  always_comb begin
    cur_blk  = full_q ? cnt_q[CNT_W-1] : cnt_q[0];
    cur_idx  = full_q ? cnt_q[POS_W-1:0] : '0;
    cur_last = (cnt_q == (full_q ? LAST_FULL : LAST_DC));
    rd_en    = active_q;
    rd_addr  = base_q + ADDR_W'({cur_blk, cur_idx});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      full_q   <= 1'b0;
      base_q   <= '0;
    end else if (go) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      full_q   <= full_in;
      base_q   <= base_in;
    end else if (active_q) begin
      cnt_q <= cnt_q + CNT_W'(1);
      if (cur_last) active_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ret_v_q    <= 1'b0;
      ret_last_q <= 1'b0;
      ret_blk_q  <= 1'b0;
      ret_full_q <= 1'b0;
      ret_idx_q  <= '0;
      ret_addr_q <= '0;
    end else begin
      ret_v_q    <= active_q;
      ret_last_q <= active_q && cur_last;
      ret_blk_q  <= cur_blk;
      ret_full_q <= full_q;
      ret_idx_q  <= cur_idx;
      ret_addr_q <= rd_addr;
    end
  end

  always_comb begin
    factor     = dq_flat[ret_idx_q*CW +: CW];
    product    = dq_mul(rd_data, factor);
    coef_data  = ret_full_q ? product : dc_round(product);
    coef_valid = ret_v_q;
    coef_blk   = ret_blk_q;
    coef_idx   = ret_idx_q;
    wr_en      = ret_v_q;
    wr_addr    = ret_addr_q;
    finished   = ret_v_q && ret_last_q;
    run_full   = full_q;
  end
endmodule

// File: rtl/dqd_dispatch.sv
module dqd_dispatch
  import dqd_pkg::*;
#(
  parameter int LUMA_PAIRS   = 8,
  parameter int CHROMA_PAIRS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               chroma,
  input  logic [NSUB*EW-1:0] eob_flat,
  input  logic [NPOS*CW-1:0] dq_flat,
  output logic               coef_rd_en,
  output logic [ADDR_W-1:0]  coef_rd_addr,
  input  logic [CW-1:0]      coef_rd_data,
  output logic               coef_wr_en,
  output logic [ADDR_W-1:0]  coef_wr_addr,
  output logic [CW-1:0]      coef_wr_data,
  output logic               xf_coef_valid,
  output logic               xf_coef_blk,
  output logic [POS_W-1:0]   xf_coef_idx,
  output logic [CW-1:0]      xf_coef_data,
  output logic               xf_cmd_valid,
  output logic               xf_cmd_full,
  output logic [1:0]         xf_cmd_plane,
  output logic [ROW_W-1:0]   xf_cmd_row,
  output logic [COL_W-1:0]   xf_cmd_col,
  input  logic               xf_done,
  output logic               done
);
  dqd_state_e        state_q;
  logic [PAIR_W-1:0] pair_q;
  logic              chroma_q, full_q, done_q;

  logic [SUB_W-1:0]  eob_sel0, eob_sel1;
  logic [ADDR_W-1:0] pair_base;
  logic              pair_last;
  logic [EW-1:0]     eob0_w, eob1_w;

  // named events for the checker
  logic pair_live_w, pair_full_w, fetch_go_w, fetch_fin_w, fetch_full_w;
  logic advance_w, finish_w;

  dqd_pair_geom #(
    .LUMA_PAIRS  (LUMA_PAIRS),
    .CHROMA_PAIRS(CHROMA_PAIRS)
  ) u_geom (
    .pair_idx(pair_q),
    .chroma  (chroma_q),
    .eob_sel0(eob_sel0),
    .eob_sel1(eob_sel1),
    .base    (pair_base),
    .plane   (xf_cmd_plane),
    .row     (xf_cmd_row),
    .col     (xf_cmd_col),
    .last    (pair_last)
  );

  always_comb begin
    eob0_w      = eob_flat[eob_sel0*EW +: EW];
    eob1_w      = eob_flat[eob_sel1*EW +: EW];
    pair_live_w = (eob0_w != '0) || (eob1_w != '0);
    pair_full_w = needs_full(eob0_w, eob1_w);
    fetch_go_w  = (state_q == ST_EVAL) && pair_live_w;
    advance_w   = ((state_q == ST_EVAL) && !pair_live_w) ||
                  ((state_q == ST_WAIT) && xf_done);
    finish_w    = advance_w && pair_last;
  end

  dqd_fetch u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (fetch_go_w),
    .full_in   (pair_full_w),
    .base_in   (pair_base),
    .dq_flat   (dq_flat),
    .rd_en     (coef_rd_en),
    .rd_addr   (coef_rd_addr),
    .rd_data   (coef_rd_data),
    .wr_en     (coef_wr_en),
    .wr_addr   (coef_wr_addr),
    .coef_valid(xf_coef_valid),
    .coef_blk  (xf_coef_blk),
    .coef_idx  (xf_coef_idx),
    .coef_data (xf_coef_data),
    .run_full  (fetch_full_w),
    .finished  (fetch_fin_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      pair_q   <= '0;
      chroma_q <= 1'b0;
      full_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= finish_w;
      unique case (state_q)
        ST_IDLE: if (start) begin
          chroma_q <= chroma;
          pair_q   <= '0;
          state_q  <= ST_EVAL;
        end
        ST_EVAL: if (pair_live_w) begin
          full_q  <= pair_full_w;
          state_q <= ST_FETCH;
        end
        ST_FETCH: if (fetch_fin_w) state_q <= ST_CMD;
        ST_CMD:   state_q <= ST_WAIT;
        ST_WAIT:  ;
        default:  state_q <= ST_IDLE;
      endcase
      if (advance_w) begin
        if (pair_last) state_q <= ST_IDLE;
        else begin
          pair_q  <= pair_q + PAIR_W'(1);
          state_q <= ST_EVAL;
        end
      end
    end
  end

  always_comb begin
    coef_wr_data = '0;
    xf_cmd_valid = (state_q == ST_CMD);
    xf_cmd_full  = full_q;
    done         = done_q;
  end
endmodule

// File: rtl/dqd_dispatch_chk.sv
module dqd_dispatch_chk
  import dqd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              coef_rd_en,
  input logic [ADDR_W-1:0] coef_rd_addr,
  input logic              coef_wr_en,
  input logic [ADDR_W-1:0] coef_wr_addr,
  input logic [CW-1:0]     coef_wr_data,
  input logic              xf_cmd_valid,
  input logic [1:0]        xf_cmd_plane,
  input logic [COL_W-1:0]  xf_cmd_col,
  input logic              xf_done,
  input logic              done,
  input logic              fetch_full_w
);
  logic pend_q;
  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= 1'b0;
    else if (xf_cmd_valid) pend_q <= 1'b1;
    else if (xf_done) pend_q <= 1'b0;
  end

  p_hold_for_engine_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> (!coef_rd_en && !xf_cmd_valid));

  p_clear_follows_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    coef_wr_en |-> ($past(coef_rd_en) && coef_wr_addr == $past(coef_rd_addr)));

  p_clear_is_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    coef_wr_en |-> coef_wr_data == '0);

  p_dc_reads_pos0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (coef_rd_en && !fetch_full_w) |-> coef_rd_addr[POS_W-1:0] == '0);

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_plane_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xf_cmd_valid |-> (xf_cmd_plane != 2'd3 &&
                      (xf_cmd_plane == 2'd0 || xf_cmd_col == '0)));
endmodule

bind dqd_dispatch dqd_dispatch_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .coef_rd_en  (coef_rd_en),
  .coef_rd_addr(coef_rd_addr),
  .coef_wr_en  (coef_wr_en),
  .coef_wr_addr(coef_wr_addr),
  .coef_wr_data(coef_wr_data),
  .xf_cmd_valid(xf_cmd_valid),
  .xf_cmd_plane(xf_cmd_plane),
  .xf_cmd_col  (xf_cmd_col),
  .xf_done     (xf_done),
  .done        (done),
  .fetch_full_w(fetch_full_w)
);

// File: tb/tb_dqd_dispatch.sv
module tb_dqd_dispatch;
  import dqd_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int MEMN = NSUB * NPOS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic chroma = 1'b0;
  logic [NSUB*EW-1:0] eob_flat;
  logic [NPOS*CW-1:0] dq_flat;
  logic coef_rd_en, coef_wr_en;
  logic [ADDR_W-1:0] coef_rd_addr, coef_wr_addr;
  logic [CW-1:0] coef_rd_data, coef_wr_data;
  logic xf_coef_valid, xf_coef_blk, xf_cmd_valid, xf_cmd_full, done;
  logic [POS_W-1:0] xf_coef_idx;
  logic [CW-1:0] xf_coef_data;
  logic [1:0] xf_cmd_plane;
  logic [ROW_W-1:0] xf_cmd_row;
  logic [COL_W-1:0] xf_cmd_col;
  logic xf_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  dqd_dispatch dut (
    .clk(clk), .rst_n(rst_n), .start(start), .chroma(chroma),
    .eob_flat(eob_flat), .dq_flat(dq_flat),
    .coef_rd_en(coef_rd_en), .coef_rd_addr(coef_rd_addr), .coef_rd_data(coef_rd_data),
    .coef_wr_en(coef_wr_en), .coef_wr_addr(coef_wr_addr), .coef_wr_data(coef_wr_data),
    .xf_coef_valid(xf_coef_valid), .xf_coef_blk(xf_coef_blk), .xf_coef_idx(xf_coef_idx),
    .xf_coef_data(xf_coef_data), .xf_cmd_valid(xf_cmd_valid), .xf_cmd_full(xf_cmd_full),
    .xf_cmd_plane(xf_cmd_plane), .xf_cmd_row(xf_cmd_row), .xf_cmd_col(xf_cmd_col),
    .xf_done(xf_done), .done(done)
  );

  // stimulus tables
  logic [EW-1:0] eob [NSUB];
  logic signed [CW-1:0] dq [NPOS];
  logic signed [CW-1:0] img [MEMN];
  logic signed [CW-1:0] mem [MEMN];
  logic ld_req = 1'b0;

  always_comb begin
    for (int i = 0; i < NSUB; i++) eob_flat[i*EW +: EW] = eob[i];
    for (int i = 0; i < NPOS; i++) dq_flat[i*CW +: CW] = dq[i];
  end

  // coefficient memory: registered read, zero-write port
  always @(posedge clk) begin
    if (ld_req) begin
      for (int i = 0; i < MEMN; i++) mem[i] <= img[i];
    end else if (coef_wr_en) mem[coef_wr_addr] <= coef_wr_data;
    if (coef_rd_en) coef_rd_data <= mem[coef_rd_addr];
  end

  // transform engine model: done four cycles after a command
  logic [2:0] eng_cnt;
  always @(posedge clk) begin
    if (!rst_n) begin
      eng_cnt <= '0;
      xf_done <= 1'b0;
    end else begin
      xf_done <= (eng_cnt == 3'd1);
      if (xf_cmd_valid) eng_cnt <= 3'd4;
      else if (eng_cnt != 0) eng_cnt <= eng_cnt - 3'd1;
    end
  end

  // monitor
  logic mon_clr = 1'b0;
  int n_cf, n_cmd, n_done, n_rd, viol;
  logic pend;
  logic [CW-1:0] cf_data [512];
  logic cf_blk [512];
  logic [POS_W-1:0] cf_idx [512];
  logic cm_full [16];
  logic [1:0] cm_plane [16];
  logic [ROW_W-1:0] cm_row [16];
  logic [COL_W-1:0] cm_col [16];

  always @(negedge clk) begin
    if (mon_clr) begin
      n_cf = 0; n_cmd = 0; n_done = 0; n_rd = 0; viol = 0; pend = 1'b0;
    end else begin
      if (coef_rd_en) n_rd++;
      if (pend && (coef_rd_en || xf_cmd_valid)) viol++;
      if (xf_done) pend = 1'b0;
      if (xf_coef_valid && n_cf < 512) begin
        cf_data[n_cf] = xf_coef_data; cf_blk[n_cf] = xf_coef_blk; cf_idx[n_cf] = xf_coef_idx;
        n_cf++;
      end
      if (xf_cmd_valid && n_cmd < 16) begin
        cm_full[n_cmd] = xf_cmd_full; cm_plane[n_cmd] = xf_cmd_plane;
        cm_row[n_cmd] = xf_cmd_row; cm_col[n_cmd] = xf_cmd_col;
        n_cmd++; pend = 1'b1;
      end
      if (done) n_done++;
    end
  end

  int n_checks = 0;
  int n_err = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // expectation
  int exp_n_cf, exp_n_cmd;
  logic [CW-1:0] ex_data [512];
  logic ex_blk [512];
  logic [POS_W-1:0] ex_idx [512];
  logic ex_full [16];
  logic [1:0] ex_plane [16];
  logic [ROW_W-1:0] ex_row [16];
  logic [COL_W-1:0] ex_col [16];
  logic signed [CW-1:0] ex_mem [MEMN];

  function automatic int wrap16(input int v);
    int w;
    w = v % 65536;
    if (w < 0) w += 65536;
    if (w >= 32768) w -= 65536;
    return w;
  endfunction

  function automatic int ref_value(input int c, input int f, input bit full);
    int w;
    w = wrap16(c * f);
    if (full) return w;
    return (w + 4 - (((w + 4) % 8 + 8) % 8)) / 8;   // floor((w+4)/8)
  endfunction

  task automatic build_expect(input bit chr);
    int np;
    np = chr ? 4 : 8;
    exp_n_cf = 0; exp_n_cmd = 0;
    for (int i = 0; i < MEMN; i++) ex_mem[i] = img[i];
    for (int p = 0; p < np; p++) begin
      int e0, e1;
      bit full;
      e0 = int'(eob[2*p]); e1 = int'(eob[2*p+1]);
      if (e0 == 0 && e1 == 0) continue;
      full = (e0 >= 2) || (e1 >= 2);
      for (int b = 0; b < 2; b++) begin
        for (int k = 0; k < (full ? 16 : 1); k++) begin
          int a;
          a = p*32 + b*16 + k;
          ex_data[exp_n_cf] = CW'(ref_value(int'(img[a]), int'(dq[k]), full));
          ex_blk[exp_n_cf] = b[0];
          ex_idx[exp_n_cf] = POS_W'(k);
          exp_n_cf++;
          ex_mem[a] = '0;
        end
      end
      ex_full[exp_n_cmd] = full;
      ex_plane[exp_n_cmd] = chr ? 2'(1 + p/2) : 2'd0;
      ex_row[exp_n_cmd] = chr ? ROW_W'(4*(p%2)) : ROW_W'(4*(p/2));
      ex_col[exp_n_cmd] = chr ? '0 : COL_W'(8*(p%2));
      exp_n_cmd++;
    end
  endtask

  int seed = 32'h1234_5678;
  function automatic int next_rand();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 8);
  endfunction

  task automatic fill_img_random(input int range);
    for (int i = 0; i < MEMN; i++) img[i] = CW'(wrap16(next_rand() % range));
  endtask

  task automatic run_block(input bit chr, input bit poke, input string tag);
    int t;
    build_expect(chr);
    @(negedge clk); ld_req = 1'b1; mon_clr = 1'b1;
    @(negedge clk); ld_req = 1'b0; mon_clr = 1'b0;
    chroma = chr; start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (poke) begin
      repeat (6) @(negedge clk);
      chroma = ~chr; start = 1'b1;
      @(negedge clk); start = 1'b0; chroma = chr;
    end
    t = 0;
    while (n_done == 0 && t < 4000) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
    chk(n_done == 1, "R8", {tag, " done pulse count"}, n_done, 1);
    chk(viol == 0, "R7", {tag, " activity while engine busy"}, viol, 0);
    chk(n_cf == exp_n_cf, "R2 R3", {tag, " coefficient count"}, n_cf, exp_n_cf);
    chk(n_rd == exp_n_cf, "R1", {tag, " read count"}, n_rd, exp_n_cf);
    begin
      int bad, ia, ie;
      bad = 0; ia = 0; ie = 0;
      for (int i = 0; i < exp_n_cf && i < n_cf; i++)
        if (bad == 0 && (cf_data[i] !== ex_data[i] || cf_blk[i] !== ex_blk[i] ||
                         cf_idx[i] !== ex_idx[i])) begin
          bad = i + 1; ia = int'($signed(cf_data[i])); ie = int'($signed(ex_data[i]));
        end
      chk(bad == 0, "R2 R3", {tag, " coefficient stream value"}, ia, ie);
    end
    chk(n_cmd == exp_n_cmd, "R5 R6", {tag, " command count"}, n_cmd, exp_n_cmd);
    begin
      int bad, ia, ie;
      bad = 0; ia = 0; ie = 0;
      for (int i = 0; i < exp_n_cmd && i < n_cmd; i++)
        if (bad == 0 && (cm_full[i] !== ex_full[i] || cm_plane[i] !== ex_plane[i] ||
                         cm_row[i] !== ex_row[i] || cm_col[i] !== ex_col[i])) begin
          bad = i + 1;
          ia = int'({cm_full[i], cm_plane[i], cm_row[i], cm_col[i]});
          ie = int'({ex_full[i], ex_plane[i], ex_row[i], ex_col[i]});
        end
      chk(bad == 0, "R5 R6", {tag, " command fields {full,plane,row,col}"}, ia, ie);
    end
    begin
      int bad, ia, ie;
      bad = 0; ia = 0; ie = 0;
      for (int i = 0; i < MEMN; i++)
        if (bad == 0 && mem[i] !== ex_mem[i]) begin
          bad = i + 1; ia = int'(mem[i]); ie = int'(ex_mem[i]);
        end
      chk(bad == 0, "R4", {tag, " memory after run"}, ia, ie);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!coef_rd_en && !coef_wr_en && !xf_coef_valid && !xf_cmd_valid && !done,
        "R9", "strobes after reset",
        int'({coef_rd_en, coef_wr_en, xf_coef_valid, xf_cmd_valid, done}), 0);
  endtask

  task automatic t_skip_all();
    for (int i = 0; i < NSUB; i++) eob[i] = '0;
    fill_img_random(2000);
    run_block(1'b0, 1'b0, "r1_skip_all");
  endtask

  task automatic t_luma_mixed();
    logic [EW-1:0] pat [NSUB];
    pat = '{8'd2, 8'd0, 8'd1, 8'd1, 8'd0, 8'd0, 8'd0, 8'd1,
            8'd1, 8'd16, 8'd255, 8'd255, 8'd1, 8'd0, 8'd0, 8'd2};
    for (int i = 0; i < NSUB; i++) eob[i] = pat[i];
    for (int i = 0; i < NPOS; i++) dq[i] = CW'(wrap16((i % 3 == 0) ? -(37 + 91*i) : (300 + 777*i)));
    fill_img_random(4000);
    run_block(1'b0, 1'b0, "r2_r5_luma_mixed");
  endtask

  task automatic t_luma_full();
    for (int i = 0; i < NSUB; i++) eob[i] = EW'(3 + i);
    for (int i = 0; i < NPOS; i++) dq[i] = CW'(5 + 11*i);
    fill_img_random(600);
    run_block(1'b0, 1'b0, "r2_luma_all_full");
  endtask

  task automatic t_dc_round();
    for (int i = 0; i < NSUB; i++) eob[i] = '0;
    eob[0] = 8'd1; eob[1] = 8'd1; eob[2] = 8'd1; eob[3] = 8'd1;
    eob[4] = 8'd1; eob[5] = 8'd0; eob[6] = 8'd0; eob[7] = 8'd1;
    for (int i = 0; i < NPOS; i++) dq[i] = CW'(7 + i);
    dq[0] = 16'sd1;
    fill_img_random(1000);
    img[0] = -16'sd5;  img[16] = 16'sd4;
    img[32] = -16'sd4; img[48] = 16'sd12;
    img[64] = 16'sd3;  img[80] = -16'sd9;
    img[96] = 16'sd300; img[112] = -16'sd1;
    run_block(1'b0, 1'b0, "r3_dc_rounding");
    dq[0] = 16'sd300;   // product wraps past 16 bits
    run_block(1'b0, 1'b0, "r3_dc_wrap");
  endtask

  task automatic t_chroma_busy();
    for (int i = 0; i < NSUB; i++) eob[i] = 8'd9;
    eob[0] = 8'd3; eob[1] = 8'd0; eob[2] = 8'd1; eob[3] = 8'd0;
    eob[4] = 8'd0; eob[5] = 8'd0; eob[6] = 8'd5; eob[7] = 8'd5;
    for (int i = 0; i < NPOS; i++) dq[i] = CW'(wrap16(-200 + 53*i));
    fill_img_random(3000);
    run_block(1'b1, 1'b1, "r6_r8_chroma_restart");
  endtask

  initial begin
    for (int i = 0; i < NSUB; i++) eob[i] = '0;
    for (int i = 0; i < NPOS; i++) dq[i] = '0;
    for (int i = 0; i < MEMN; i++) img[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_skip_all();
    t_luma_mixed();
    t_luma_full();
    t_dc_round();
    t_chroma_busy();
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end
endmodule